// File: doc/BRIEF.md
# NAND Page Read Sequencer with In-Page Column Relocation

This block drives an 8-bit NAND flash bus to load one page into the device's page register. It then streams the page bytes to the host, one byte per read strobe, and the internal column moves forward by one on every byte. The host starts a read by giving a row address and a starting column.

While the stream runs, the host may move the read position inside the page. To do this it presents a new column for one cycle. The block then issues the short relocation sequence on the bus, so no new page read is needed, and the stream continues from the new column. This can be repeated any number of times within one page read.

A column at or beyond the end of the page plus its spare area is refused and flagged. The stream ends at the last spare byte or when the host withdraws its read request. The final byte carries an end marker. The block's own copy of the column is brought out so it can be observed.

Top module: `nand_colseq`

## Requirements
- R1: A page read issues command 0x00, then two column cycles (bits 7:0 first, then bits 11:8 in the low nibble), then ROW_CYC row cycles with the least significant byte first, then command 0x30. After that it waits for nand_rb_n to go low and then high. No read strobe ever falls while nand_rb_n is low.
- R2: Each read strobe produces one byte on dout with dout_valid high for one cycle. During that cycle cur_col shows the column the byte came from, and that column then advances by one.
- R3: A relocation issues command 0x05, then two column cycles in the R1 layout, then command 0xE0. The next byte comes from the new column, and cur_col shows it.
- R4: Any number of relocations may occur within one page read, and each one is honoured in turn.
- R5: A column of 2112 or more is refused. On col_req, err is set and both the stream and cur_col continue as if nothing had been requested. On start, err is set and no bus activity begins: nand_ce_n stays high and busy stays low.
- R6: At least GAP_CYC+1 clock cycles separate the rise of the write strobe that carries 0xE0 from the next fall of the read strobe.
- R7: The byte from column 2111 carries dout_last unless a relocation is pending. After it, the block goes idle with cur_col at 2112.
- R8: A byte delivered while rd_req is low carries dout_last, and the read ends.
- R9: A valid col_req in the same cycle as the column-2111 byte clears dout_last, and the stream continues at the requested column. If rd_req is low in that cycle, the end wins: dout_last is set and the request is dropped without any bus activity.
- R10: After reset, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle and nand_ale are low, and dout_valid, busy and err are low.
- R11: An accepted start clears err.
- R12: A valid col_req in the cycle a byte is delivered takes effect for the very next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a page read (taken when idle) |
| start_row | input | ROW_CYC*8 | Row address of the page |
| start_col | input | COL_W | First column to stream |
| rd_req | input | 1 | Host wants more bytes |
| col_req | input | 1 | One-cycle request to relocate the column |
| col_val | input | COL_W | Requested new column |
| dout_valid | output | 1 | Byte on dout is valid |
| dout | output | 8 | Streamed byte |
| dout_last | output | 1 | This byte ends the read |
| busy | output | 1 | A page read is in progress |
| err | output | 1 | Sticky flag: a column was refused |
| cur_col | output | COL_W | Block's current column |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value driven to device |
| nand_io_oe | output | 1 | Drive enable for nand_io_out |
| nand_io_in | input | 8 | Bus value from device |
| nand_rb_n | input | 1 | Ready (high) / busy (low) |

## Verification
The two functions that can fall in the same cycle are the end-of-stream decision and the acceptance of a column relocation. The bench waits for the delivery of the column-2111 byte and raises col_req in that cycle, then re-reads dout_last after a short delay. It expects the marker to be cleared and the next byte to come from the new column. It also lowers rd_req together with col_req and expects the marker, a return to idle and no 0x05 command in the device model's command log.

// File: rtl/nand_colseq_pkg.sv
`timescale 1ns/1ps
package nand_colseq_pkg;
    typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_READ} bus_op_t;
    typedef enum logic [1:0] {PH_IDLE, PH_ACT, PH_REL} bus_ph_t;
    typedef enum logic [3:0] {
        S_IDLE, S_PCMD, S_PADR, S_PCONF, S_WBSY, S_WRDY,
        S_STRM, S_RCMD, S_RADR, S_RCONF, S_GAP
    } seq_st_t;
    localparam logic [7:0] CMD_PAGE_A = 8'h00;
    localparam logic [7:0] CMD_PAGE_B = 8'h30;
    localparam logic [7:0] CMD_MOVE_A = 8'h05;
    localparam logic [7:0] CMD_MOVE_B = 8'hE0;
endpackage

// File: rtl/nand_colseq_colchk.sv
`timescale 1ns/1ps
module nand_colseq_colchk #(
    parameter int COL_W = 12,
    parameter int LIMIT = 2112
) (
    input  logic [COL_W-1:0] col,
    output logic             ok
);
    assign ok = (32'(col) < LIMIT);
endmodule

// File: rtl/nand_colseq_bus.sv
`timescale 1ns/1ps
module nand_colseq_bus
    import nand_colseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  bus_op_t    op,
    input  logic [7:0] wbyte,
    output logic       idle,
    output logic       done,
    output logic [7:0] rdata,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    input  logic [7:0] io_in
);
    typedef struct packed {
        bus_ph_t    ph;
        bus_op_t    op;
        logic [7:0] wb;
        logic [7:0] rd;
    } bus_reg_t;

    bus_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.ph)
            PH_IDLE: if (go) begin
                r_d.ph = PH_ACT;
                r_d.op = op;
                r_d.wb = wbyte;
            end
            PH_ACT: begin
                r_d.ph = PH_REL;
                if (r_q.op == OP_READ) r_d.rd = io_in;
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ph: PH_IDLE, op: OP_CMD, wb: 8'h00, rd: 8'h00};
        else        r_q <= r_d;
    end

    assign idle   = (r_q.ph == PH_IDLE);
    assign done   = (r_q.ph == PH_REL);
    assign rdata  = r_q.rd;
    assign cle    = (r_q.ph != PH_IDLE) && (r_q.op == OP_CMD);
    assign ale    = (r_q.ph != PH_IDLE) && (r_q.op == OP_ADDR);
    assign we_n   = !((r_q.ph == PH_ACT) && (r_q.op != OP_READ));
    assign re_n   = !((r_q.ph == PH_ACT) && (r_q.op == OP_READ));
    assign io_oe  = (r_q.ph != PH_IDLE) && (r_q.op != OP_READ);
    assign io_out = r_q.wb;

    // R1: bus value stays put while the write strobe rises
    p_io_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> $stable(io_out));
endmodule

// File: rtl/nand_colseq.sv
`timescale 1ns/1ps
module nand_colseq
    import nand_colseq_pkg::*;
#(
    parameter int PAGE_DATA  = 2048,
    parameter int PAGE_SPARE = 64,
    parameter int COL_W      = 12,
    parameter int ROW_CYC    = 3,
    parameter int GAP_CYC    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ROW_CYC*8-1:0] start_row,
    input  logic [COL_W-1:0]     start_col,
    input  logic                 rd_req,
    input  logic                 col_req,
    input  logic [COL_W-1:0]     col_val,
    output logic                 dout_valid,
    output logic [7:0]           dout,
    output logic                 dout_last,
    output logic                 busy,
    output logic                 err,
    output logic [COL_W-1:0]     cur_col,
    output logic                 nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic [7:0]           nand_io_out,
    output logic                 nand_io_oe,
    input  logic [7:0]           nand_io_in,
    input  logic                 nand_rb_n
);
    localparam int PAGE_BYTES = PAGE_DATA + PAGE_SPARE;
    localparam int ROW_W      = ROW_CYC * 8;
    localparam int ADR_CYC    = 2 + ROW_CYC;
    localparam int IDX_W      = $clog2(ADR_CYC + 1);
    localparam int GAP_W      = $clog2(GAP_CYC + 1);
    localparam logic [IDX_W-1:0] ADR_LAST = IDX_W'(ADR_CYC - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
    localparam logic [COL_W-1:0] COL_END  = COL_W'(PAGE_BYTES - 1);

    typedef struct packed {
        seq_st_t          st;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] tgt;
        logic [ROW_W-1:0] row;
        logic             pend;
        logic [COL_W-1:0] pcol;
        logic [IDX_W-1:0] idx;
        logic [GAP_W-1:0] gap;
        logic             fly;
        logic             err;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    // column range checks for the request port and the start port
    logic [1:0][COL_W-1:0] chk_col;
    logic [1:0]            chk_ok;
    assign chk_col[0] = col_val;
    assign chk_col[1] = start_col;
    for (genvar g = 0; g < 2; g++) begin : g_chk
        nand_colseq_colchk #(.COL_W(COL_W), .LIMIT(PAGE_BYTES)) u_chk (
            .col (chk_col[g]),
            .ok  (chk_ok[g])
        );
    end
    logic req_ok, start_ok;
    assign req_ok   = chk_ok[0];
    assign start_ok = chk_ok[1];

    logic       bus_go, bus_idle, bus_done;
    bus_op_t    bus_op;
    logic [7:0] bus_wb, bus_rd;

    nand_colseq_bus u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (bus_go),
        .op     (bus_op),
        .wbyte  (bus_wb),
        .idle   (bus_idle),
        .done   (bus_done),
        .rdata  (bus_rd),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .io_out (nand_io_out),
        .io_oe  (nand_io_oe),
        .io_in  (nand_io_in)
    );

    logic             active, issue, reloc_now, at_end;
    logic             d_valid, d_last;
    logic [COL_W-1:0] acol;
    logic [7:0]       adr_byte;

    assign active    = (r_q.st != S_IDLE);
    assign issue     = bus_idle && !r_q.fly;
    assign reloc_now = r_q.pend || (col_req && req_ok);
    assign at_end    = (r_q.col == COL_END);

    always_comb begin
        acol = (r_q.st == S_RADR) ? r_q.tgt : r_q.col;
        if (r_q.idx == '0)
            adr_byte = acol[7:0];
        else if (r_q.idx == IDX_W'(1))
            adr_byte = 8'(acol >> 8);
        else
            adr_byte = 8'(r_q.row >> (8 * (32'(r_q.idx) - 2)));
    end

    always_comb begin
        r_d     = r_q;
        bus_go  = 1'b0;
        bus_op  = OP_CMD;
        bus_wb  = 8'h00;
        d_valid = 1'b0;
        d_last  = 1'b0;
        if (active && col_req) begin
            if (req_ok) begin
                r_d.pend = 1'b1;
                r_d.pcol = col_val;
            end else begin
                r_d.err = 1'b1;
            end
        end
        if (bus_done) r_d.fly = 1'b0;
        unique case (r_q.st)
            S_IDLE: if (start) begin
                if (start_ok) begin
                    r_d.st   = S_PCMD;
                    r_d.col  = start_col;
                    r_d.row  = start_row;
                    r_d.err  = 1'b0;
                    r_d.pend = 1'b0;
                    r_d.idx  = '0;
                end else begin
                    r_d.err = 1'b1;
                end
            end
            S_PCMD: begin
                bus_wb = CMD_PAGE_A;
                bus_go = issue;
                if (bus_done) r_d.st = S_PADR;
            end
            S_PADR: begin
                bus_op = OP_ADDR;
                bus_wb = adr_byte;
                bus_go = issue;
                if (bus_done) begin
                    if (r_q.idx == ADR_LAST) r_d.st = S_PCONF;
                    else r_d.idx = r_q.idx + 1'b1;
                end
            end
            S_PCONF: begin
                bus_wb = CMD_PAGE_B;
                bus_go = issue;
                if (bus_done) r_d.st = S_WBSY;
            end
            S_WBSY: if (!nand_rb_n) r_d.st = S_WRDY;
            S_WRDY: if (nand_rb_n)  r_d.st = S_STRM;
            S_STRM: begin
                bus_op = OP_READ;
                if (bus_done) begin
                    d_valid = 1'b1;
                    r_d.col = r_q.col + 1'b1;
                    if (!rd_req || (at_end && !reloc_now)) begin
                        d_last   = 1'b1;
                        r_d.st   = S_IDLE;
                        r_d.pend = 1'b0;
                    end
                end else if (issue) begin
                    if (reloc_now) begin
                        r_d.tgt  = (col_req && req_ok) ? col_val : r_q.pcol;
                        r_d.pend = 1'b0;
                        r_d.idx  = '0;
                        r_d.st   = S_RCMD;
                    end else begin
                        bus_go = 1'b1;
                    end
                end
            end
            S_RCMD: begin
                bus_wb = CMD_MOVE_A;
                bus_go = issue;
                if (bus_done) r_d.st = S_RADR;
            end
            S_RADR: begin
                bus_op = OP_ADDR;
                bus_wb = adr_byte;
                bus_go = issue;
                if (bus_done) begin
                    if (r_q.idx == IDX_W'(1)) r_d.st = S_RCONF;
                    else r_d.idx = r_q.idx + 1'b1;
                end
            end
            S_RCONF: begin
                bus_wb = CMD_MOVE_B;
                bus_go = issue;
                if (bus_done) begin
                    r_d.col = r_q.tgt;
                    r_d.gap = '0;
                    r_d.st  = S_GAP;
                end
            end
            S_GAP: begin
                if (r_q.gap == GAP_LAST) r_d.st = S_STRM;
                else r_d.gap = r_q.gap + 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
        if (bus_go) r_d.fly = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign dout_valid = d_valid;
    assign dout_last  = d_last;
    assign dout       = bus_rd;
    assign busy       = active;
    assign nand_ce_n  = !active;
    assign err        = r_q.err;
    assign cur_col    = r_q.col;

    p_ready_before_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> nand_rb_n);
    p_gap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_GAP) |-> (nand_re_n && nand_we_n));
    p_bad_col_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && col_req && !req_ok && !bus_done) |=> $stable(cur_col));
    p_bad_start_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start && !start_ok) |=> (err && !busy));
    p_col_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cur_col) <= PAGE_BYTES);
    p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_last |=> !busy);
endmodule

// File: tb/nand_colseq_tb_top.sv
`timescale 1ns/1ps
module nand_colseq_tb_top;
    localparam int GAP  = 4;
    localparam int PAGE = 2112;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rd_req = 1'b0, col_req = 1'b0;
    logic [23:0] start_row = '0;
    logic [11:0] start_col = '0, col_val = '0;
    logic dout_valid, dout_last, busy, err;
    logic [7:0] dout;
    logic [11:0] cur_col;
    logic ce_n, cle, ale, we_n, re_n, io_oe;
    logic [7:0] io_out;
    logic [7:0] io_in = 8'h00;
    logic rb_n = 1'b1;

    always #10 clk = ~clk;

    nand_colseq #(.GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
        .start_col(start_col), .rd_req(rd_req), .col_req(col_req), .col_val(col_val),
        .dout_valid(dout_valid), .dout(dout), .dout_last(dout_last), .busy(busy),
        .err(err), .cur_col(cur_col), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
        .nand_we_n(we_n), .nand_re_n(re_n), .nand_io_out(io_out), .nand_io_oe(io_oe),
        .nand_io_in(io_in), .nand_rb_n(rb_n)
    );

    // device model: sampled on the falling clock edge
    int cyc = 0, mlog_n = 0, acnt = 0, bcnt = 0, min_gap = 9999, e0_cyc = 0, viol = 0;
    logic e0_wait = 1'b0, we_prev = 1'b1, re_prev = 1'b1;
    logic [7:0] mcmd = 8'hFF;
    logic [11:0] mcol = '0, mptr = '0;
    logic [23:0] mrow = '0;
    logic [8:0] mlog [0:63];

    function automatic logic [7:0] pat(input logic [23:0] rw, input logic [11:0] c);
        return c[7:0] ^ {c[11:8], c[11:8]} ^ rw[7:0] ^ rw[15:8] ^ 8'h5A;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (bcnt > 0) begin
            bcnt--;
            if (bcnt == 0) rb_n = 1'b1;
        end
        if (we_n && !we_prev) begin
            if (mlog_n < 64) mlog[mlog_n] = {cle, io_out};
            mlog_n++;
            if (cle) begin
                mcmd = io_out;
                acnt = 0;
                if (io_out == 8'h30) begin mptr = mcol; rb_n = 1'b0; bcnt = 6; end
                if (io_out == 8'hE0) begin mptr = mcol; e0_cyc = cyc; e0_wait = 1'b1; end
            end else if (ale) begin
                if (acnt == 0) mcol[7:0] = io_out;
                else if (acnt == 1) mcol[11:8] = io_out[3:0];
                else if (acnt < 5) mrow[8*(acnt-2) +: 8] = io_out;
                acnt++;
            end
        end
        if (!re_n && re_prev) begin
            if (!rb_n) viol++;
            io_in = pat(mrow, mptr);
            if (e0_wait) begin
                if (cyc - e0_cyc < min_gap) min_gap = cyc - e0_cyc;
                e0_wait = 1'b0;
            end
        end
        if (re_n && !re_prev) mptr = mptr + 1'b1;
        we_prev = we_n;
        re_prev = re_n;
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [23:0] rw, input logic [11:0] c);
        @(negedge clk);
        start = 1'b1; start_row = rw; start_col = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] d, output logic lst, output logic [11:0] cc);
        d = 8'h00; lst = 1'b0; cc = '0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (dout_valid) begin
                d = dout; lst = dout_last; cc = cur_col;
                return;
            end
        end
        chk(1'b0, "R2 byte timeout", 0, 1);
    endtask

    // byte must match the expected column; tag names the requirement
    task automatic expect_byte(input string tag, input logic [23:0] rw, input logic [11:0] c,
                               input logic want_last);
        logic [7:0] d; logic l; logic [11:0] cc;
        get_byte(d, l, cc);
        chk(d == pat(rw, c), {tag, " data"}, d, pat(rw, c));
        chk(cc == c, {tag, " cur_col"}, cc, c);
        chk(l == want_last, {tag, " last"}, l, want_last);
    endtask

    task automatic send_col(input logic [11:0] c);
        col_req = 1'b1; col_val = c;
        @(negedge clk);
        col_req = 1'b0;
    endtask

    task automatic stop_read();
        @(posedge clk); #1 rd_req = 1'b0;
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ce_n && we_n && re_n, "R10 strobes idle", {ce_n, we_n, re_n}, 7);
        chk(!cle && !ale, "R10 latches low", {cle, ale}, 0);
        chk(!dout_valid && !busy && !err, "R10 flags low", {dout_valid, busy, err}, 0);
    endtask

    task automatic t_sequential();
        int base;
        base = mlog_n;
        rd_req = 1'b1;
        do_start(24'h3C1A52, 12'd100);
        for (int k = 0; k < 5; k++) expect_byte("R2", 24'h3C1A52, 12'(100 + k), 1'b0);
        @(posedge clk); #1 rd_req = 1'b0;
        expect_byte("R8", 24'h3C1A52, 12'd105, 1'b1);
        @(negedge clk);
        chk(!busy && ce_n, "R8 idle after last", busy, 0);
        chk(mlog[base] == 9'h100, "R1 cmd 00", mlog[base], 9'h100);
        chk(mlog[base+1] == 9'h064 && mlog[base+2] == 9'h000, "R1 column cycles",
            {mlog[base+1], mlog[base+2]}, 18'h0C800);
        chk(mlog[base+3] == 9'h052 && mlog[base+4] == 9'h01A && mlog[base+5] == 9'h03C,
            "R1 row cycles", mlog[base+3], 9'h052);
        chk(mlog[base+6] == 9'h130, "R1 cmd 30", mlog[base+6], 9'h130);
        chk(viol == 0, "R1 read while busy", viol, 0);
    endtask

    task automatic t_end_of_page();
        rd_req = 1'b1;
        do_start(24'h000101, 12'd2108);
        for (int k = 0; k < 3; k++) expect_byte("R7", 24'h000101, 12'(2108 + k), 1'b0);
        expect_byte("R7", 24'h000101, 12'd2111, 1'b1);
        @(negedge clk);
        chk(!busy && ce_n, "R7 idle", busy, 0);
        chk(cur_col == 12'(PAGE), "R7 cur_col past end", cur_col, PAGE);
        rd_req = 1'b0;
    endtask

    task automatic t_relocate();
        int base;
        logic [7:0] d; logic l; logic [11:0] cc;
        base = mlog_n;
        min_gap = 9999;
        rd_req = 1'b1;
        do_start(24'h00AB00, 12'd10);
        expect_byte("R2", 24'h00AB00, 12'd10, 1'b0);
        get_byte(d, l, cc);
        chk(d == pat(24'h00AB00, 12'd11), "R2 data", d, pat(24'h00AB00, 12'd11));
        send_col(12'd700);
        expect_byte("R12", 24'h00AB00, 12'd700, 1'b0);
        chk(mlog[base+7] == 9'h105, "R3 cmd 05", mlog[base+7], 9'h105);
        chk(mlog[base+8] == 9'h0BC && mlog[base+9] == 9'h002, "R3 column cycles",
            mlog[base+8], 9'h0BC);
        chk(mlog[base+10] == 9'h1E0, "R3 cmd E0", mlog[base+10], 9'h1E0);
        get_byte(d, l, cc);
        chk(cc == 12'd701, "R3 sequential after move", cc, 701);
        send_col(12'd2000);
        expect_byte("R4", 24'h00AB00, 12'd2000, 1'b0);
        get_byte(d, l, cc);
        send_col(12'd5);
        expect_byte("R4", 24'h00AB00, 12'd5, 1'b0);
        expect_byte("R4", 24'h00AB00, 12'd6, 1'b0);
        chk(min_gap >= GAP + 1, "R6 gap after E0", min_gap, GAP + 1);
        stop_read();
    endtask

    task automatic t_bad_column();
        logic [7:0] d; logic l; logic [11:0] cc;
        do_start(24'h000011, 12'd2112);
        @(negedge clk);
        chk(err, "R5 bad start flag", err, 1);
        chk(ce_n && !busy, "R5 bad start no bus", busy, 0);
        rd_req = 1'b1;
        do_start(24'h000011, 12'd300);
        @(negedge clk);
        chk(!err, "R11 start clears err", err, 0);
        get_byte(d, l, cc);
        col_req = 1'b1; col_val = 12'd3000;
        @(negedge clk);
        col_req = 1'b0;
        chk(cur_col == 12'd301, "R5 cur_col kept", cur_col, 301);
        chk(err, "R5 bad request flag", err, 1);
        expect_byte("R5", 24'h000011, 12'd301, 1'b0);
        stop_read();
    endtask

    task automatic t_collision();
        logic [7:0] d; logic l; logic [11:0] cc;
        int base;
        rd_req = 1'b1;
        do_start(24'h000077, 12'd2110);
        expect_byte("R9", 24'h000077, 12'd2110, 1'b0);
        get_byte(d, l, cc);
        col_req = 1'b1; col_val = 12'd40;
        #1;
        chk(cc == 12'd2111 && dout_valid && !dout_last, "R9 move beats end",
            dout_last, 0);
        @(negedge clk);
        col_req = 1'b0;
        expect_byte("R9", 24'h000077, 12'd40, 1'b0);
        get_byte(d, l, cc);
        base = mlog_n;
        rd_req = 1'b0; col_req = 1'b1; col_val = 12'd60;
        #1;
        chk(dout_last, "R9 end beats move", dout_last, 1);
        @(negedge clk);
        col_req = 1'b0;
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk(!busy, "R9 idle after end", busy, 0);
        chk(mlog_n == base, "R9 no relocation issued", mlog_n, base);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequential();
        t_end_of_page();
        t_relocate();
        t_bad_column();
        t_collision();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule